// File: doc/BRIEF.md
# Page Program Buffer and Cycle Timer

This block sits behind the serial command decoder of a small serial-interface EEPROM. It gathers the data bytes of one array write into a page-sized buffer. When chip select rises, it decides whether the sequence ended cleanly. If it did, it runs a self-timed programming cycle. On the last clock of that cycle it commits the buffered bytes to the memory array, or the new byte to the status register, in one wide write.

The decoder marks the start of a sequence with `seq_start`. With it come the target address and whether the target is the array or the status register. Each completed byte arrives on `rx_valid`/`rx_byte`. The deselect arrives on `desel`, together with `desel_bits`, the number of bits clocked into the byte that was in progress. Byte n of a sequence goes to in-page offset (start offset + n) mod page size, so a long sequence wraps and overwrites the bytes it wrote earlier. The array write port has one enable per byte lane, and only the lanes written in the current sequence are enabled. The cycle length `CYCLE_CLKS` is counted in system clocks. Its default is a 10 ms cycle at 100 MHz.

Top module: `page_prog_engine`

## Requirements
- R1: After reset, `busy`, `wel_clr`, `arr_we` and `sr_we` are all 0.
- R2: An array sequence commits when `desel` arrives with `desel_bits` = 0 after at least one byte. `busy` then rises on the next clock and stays high for exactly `CYCLE_CLKS` cycles.
- R3: In the last busy cycle, `arr_we` pulses for one cycle and `wel_clr` is high in the same cycle. `arr_page` is `seq_addr[ADDR_W-1:4]`. `arr_be` bit k is set only for the offsets k written in this sequence. `arr_wdata[8k+7:8k]` holds the last byte written to offset k. `busy` is 0 on the next cycle.
- R4: The first byte goes to offset `seq_addr[3:0]` and each later byte to the next offset, wrapping from 15 to 0. A later byte at the same offset replaces the earlier one.
- R5: A deselect with `desel_bits` not equal to 0 cancels the sequence: no cycle starts and no write strobe appears.
- R6: A deselect before any data byte cancels the sequence.
- R7: A status sequence (`seq_is_status` = 1) commits only if exactly one byte was received and `desel_bits` = 0. It then runs the same timed cycle and pulses `sr_we` with `sr_wdata` equal to that byte instead of `arr_we`. Two or more bytes, or a partial byte, cancel it.
- R8: While `busy` is high, `seq_start`, `rx_valid` and `desel` are ignored. The running cycle writes the bytes it was committed with, and a start presented in the last busy cycle leaves no sequence open.
- R9: A byte presented in the same cycle as `desel` is part of the sequence and counts toward the commit decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_start | input | 1 | Start of a write sequence (one-cycle pulse) |
| seq_is_status | input | 1 | 1: status-register target, 0: array target |
| seq_addr | input | ADDR_W | Start address of an array sequence |
| rx_valid | input | 1 | A complete data byte is on `rx_byte` |
| rx_byte | input | 8 | Received data byte |
| desel | input | 1 | Chip select rose (one-cycle pulse) |
| desel_bits | input | 3 | Bits of the unfinished byte at deselect |
| busy | output | 1 | Programming cycle in progress |
| wel_clr | output | 1 | Clears the write enable latch, end of cycle |
| arr_we | output | 1 | Array page write strobe |
| arr_page | output | ADDR_W-4 | Page number for the array write |
| arr_be | output | 16 | Per-byte write enables |
| arr_wdata | output | 128 | Page data, lane k at bits 8k+7:8k |
| sr_we | output | 1 | Status register write strobe |
| sr_wdata | output | 8 | Status byte to write |

## Verification
The risky collision is a new sequence that lands on the last busy clock, the same clock in which the timer commits the old buffer and drops `busy`. The bench waits until `wel_clr` is seen. It then drives `seq_start` so that it is sampled in that same last cycle, and afterwards sends a byte and a clean deselect. A correct design must produce no second write strobe and must keep `busy` low. The bench also sends bytes and a deselect earlier in the busy window. The scoreboard compares the committed page data against the bytes of the original sequence, which shows that none of those later bytes reached the buffer.

// File: rtl/ppe_pkg.sv
package ppe_pkg;
  typedef enum logic {
    KIND_ARRAY  = 1'b0,
    KIND_STATUS = 1'b1
  } wr_kind_e;
endpackage

// File: rtl/ppe_collect.sv
module ppe_collect
  import ppe_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              busy_i,
  input  logic                              seq_start_i,
  input  logic                              seq_is_status_i,
  input  logic [ADDR_W-1:0]                 seq_addr_i,
  input  logic                              rx_valid_i,
  input  logic [7:0]                        rx_byte_i,
  input  logic                              desel_i,
  input  logic [2:0]                        desel_bits_i,
  output logic                              commit_o,
  output wr_kind_e                          kind_o,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_o,
  output logic [PAGE_BYTES-1:0]             be_o,
  output logic [PAGE_BYTES*8-1:0]           data_o,
  output logic [7:0]                        sr_byte_o
);
  localparam int PAGE_AW = $clog2(PAGE_BYTES);
  localparam int PAGE_W  = ADDR_W - PAGE_AW;
  localparam logic [PAGE_AW-1:0] OFF_MAX = PAGE_AW'(PAGE_BYTES - 1);

  logic               active_q, active_d;
  wr_kind_e           kind_q, kind_d;
  logic [PAGE_W-1:0]  page_q, page_d;
  logic [PAGE_AW-1:0] off_q, off_d;
  logic [1:0]         cnt_q, cnt_d;
  logic [7:0]         sr_q, sr_d;

  logic start_go, take, close;
  assign start_go = !busy_i && seq_start_i;
  assign take     = !busy_i && active_q && !seq_start_i && rx_valid_i;
  assign close    = !busy_i && active_q && !seq_start_i && desel_i;

  always_comb begin
    active_d = active_q;
    kind_d   = kind_q;
    page_d   = page_q;
    off_d    = off_q;
    cnt_d    = cnt_q;
    sr_d     = sr_q;
    if (start_go) begin
      active_d = 1'b1;
      kind_d   = seq_is_status_i ? KIND_STATUS : KIND_ARRAY;
      page_d   = seq_addr_i[ADDR_W-1:PAGE_AW];
      off_d    = seq_addr_i[PAGE_AW-1:0];
      cnt_d    = 2'd0;
    end else begin
      if (take) begin
        off_d = off_q + 1'b1;
        if (cnt_q != 2'd2) cnt_d = cnt_q + 2'd1;
        if (kind_q == KIND_STATUS) sr_d = rx_byte_i;
      end
      if (close) active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      kind_q   <= KIND_ARRAY;
      page_q   <= '0;
      off_q    <= '0;
      cnt_q    <= 2'd0;
      sr_q     <= 8'h00;
    end else begin
      active_q <= active_d;
      kind_q   <= kind_d;
      page_q   <= page_d;
      off_q    <= off_d;
      cnt_q    <= cnt_d;
      sr_q     <= sr_d;
    end
  end

  // one register lane per page byte, with its own write flag
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
    logic       hit_q;
    logic [7:0] byte_q;
    logic       lane_wr;
    assign lane_wr = take && (kind_q == KIND_ARRAY) && (off_q == PAGE_AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit_q  <= 1'b0;
        byte_q <= 8'h00;
      end else if (start_go) begin
        hit_q  <= 1'b0;
      end else if (lane_wr) begin
        hit_q  <= 1'b1;
        byte_q <= rx_byte_i;
      end
    end
    assign be_o[g]         = hit_q;
    assign data_o[g*8 +: 8] = byte_q;
  end

  assign commit_o = close && (desel_bits_i == 3'd0) &&
                    ((kind_q == KIND_STATUS) ? (cnt_d == 2'd1) : (cnt_d != 2'd0));
  assign kind_o    = kind_q;
  assign page_o    = page_q;
  assign sr_byte_o = sr_q;

  AST_OFFSET_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && off_q == OFF_MAX) |=> (off_q == '0)); // R4
  AST_BUFFER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(be_o) && $stable(data_o) && $stable(sr_byte_o))); // R8
  AST_NO_OPEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !active_q) |=> !active_q); // R8
endmodule

// File: rtl/ppe_timer.sv
module ppe_timer
  import ppe_pkg::*;
#(
  parameter int CYCLE_CLKS = 1000000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     commit_i,
  input  wr_kind_e kind_i,
  output logic     busy_o,
  output logic     done_o,
  output wr_kind_e kind_o
);
  localparam int CNT_W = (CYCLE_CLKS > 1) ? $clog2(CYCLE_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLE_CLKS - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  wr_kind_e         kind_q, kind_d;

  assign done_o = busy_q && (cnt_q == LAST);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    if (!busy_q) begin
      if (commit_i) begin
        busy_d = 1'b1;
        cnt_d  = '0;
        kind_d = kind_i;
      end
    end else if (done_o) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= KIND_ARRAY;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
    end
  end

  assign busy_o = busy_q;
  assign kind_o = kind_q;

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o); // R2
  AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(commit_i)); // R2
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o); // R3
endmodule

// File: rtl/page_prog_engine.sv
module page_prog_engine
  import ppe_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 16,
  parameter int CYCLE_CLKS = 1000000
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  seq_start,
  input  logic                                  seq_is_status,
  input  logic [ADDR_W-1:0]                     seq_addr,
  input  logic                                  rx_valid,
  input  logic [7:0]                            rx_byte,
  input  logic                                  desel,
  input  logic [2:0]                            desel_bits,
  output logic                                  busy,
  output logic                                  wel_clr,
  output logic                                  arr_we,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]  arr_page,
  output logic [PAGE_BYTES-1:0]                 arr_be,
  output logic [PAGE_BYTES*8-1:0]               arr_wdata,
  output logic                                  sr_we,
  output logic [7:0]                            sr_wdata
);
  logic     commit, done;
  wr_kind_e req_kind, run_kind;

  ppe_collect #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_collect (
    .clk             (clk),
    .rst_n           (rst_n),
    .busy_i          (busy),
    .seq_start_i     (seq_start),
    .seq_is_status_i (seq_is_status),
    .seq_addr_i      (seq_addr),
    .rx_valid_i      (rx_valid),
    .rx_byte_i       (rx_byte),
    .desel_i         (desel),
    .desel_bits_i    (desel_bits),
    .commit_o        (commit),
    .kind_o          (req_kind),
    .page_o          (arr_page),
    .be_o            (arr_be),
    .data_o          (arr_wdata),
    .sr_byte_o       (sr_wdata)
  );

  ppe_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (commit),
    .kind_i   (req_kind),
    .busy_o   (busy),
    .done_o   (done),
    .kind_o   (run_kind)
  );

  assign wel_clr = done;
  assign arr_we  = done && (run_kind == KIND_ARRAY);
  assign sr_we   = done && (run_kind == KIND_STATUS);

  AST_STROBE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we || sr_we) |-> (busy && wel_clr)); // R3
  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_we, sr_we})); // R7
endmodule

// File: tb/page_prog_engine_bench.sv
module page_prog_engine_bench;
  localparam int AW  = 10;
  localparam int PB  = 16;
  localparam int CYC = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         seq_start = 1'b0, seq_is_status = 1'b0;
  logic [AW-1:0] seq_addr = '0;
  logic         rx_valid = 1'b0;
  logic [7:0]   rx_byte = 8'h00;
  logic         desel = 1'b0;
  logic [2:0]   desel_bits = 3'd0;
  logic         busy, wel_clr, arr_we, sr_we;
  logic [5:0]   arr_page;
  logic [15:0]  arr_be;
  logic [127:0] arr_wdata;
  logic [7:0]   sr_wdata;

  page_prog_engine #(.ADDR_W(AW), .PAGE_BYTES(PB), .CYCLE_CLKS(CYC)) u_page_prog_engine (
    .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .seq_is_status(seq_is_status),
    .seq_addr(seq_addr), .rx_valid(rx_valid), .rx_byte(rx_byte), .desel(desel),
    .desel_bits(desel_bits), .busy(busy), .wel_clr(wel_clr), .arr_we(arr_we),
    .arr_page(arr_page), .arr_be(arr_be), .arr_wdata(arr_wdata), .sr_we(sr_we),
    .sr_wdata(sr_wdata));

  always #5 clk = ~clk;

  typedef struct packed {
    logic         is_sr;
    logic [5:0]   page;
    logic [15:0]  be;
    logic [127:0] data;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  int run    = 0;
  logic [7:0] pl [0:31];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: compare strobes against the scoreboard, measure busy length
  always @(negedge clk) begin
    if (rst_n) begin
      if (arr_we || sr_we) begin
        if (q.size() == 0) begin
          chk(1'b0, "R8", "unexpected write strobe", {arr_we, sr_we}, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(sr_we == e.is_sr && arr_we == !e.is_sr, e.is_sr ? "R7" : "R3",
              "strobe target", {arr_we, sr_we}, {!e.is_sr, e.is_sr});
          chk(wel_clr == 1'b1, "R3", "wel_clr with strobe", wel_clr, 1);
          if (e.is_sr) begin
            chk(sr_wdata == e.data[7:0], "R7", "status byte", sr_wdata, e.data[7:0]);
          end else begin
            chk(arr_page == e.page, "R3", "page", arr_page, e.page);
            chk(arr_be == e.be, "R4", "byte enables", arr_be, e.be);
            chk((arr_wdata & mask(e.be)) == (e.data & mask(e.be)), "R4",
                "page data", arr_wdata & mask(e.be), e.data & mask(e.be));
          end
        end
      end
      if (busy) run++;
      else if (run != 0) begin
        chk(run == CYC, "R2", "busy length", run, CYC);
        run = 0;
      end
    end
  end

  function automatic logic [127:0] mask(input logic [15:0] be);
    logic [127:0] m = '0;
    for (int k = 0; k < 16; k++) if (be[k]) m[k*8 +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic start_seq(input bit st, input logic [AW-1:0] a);
    seq_start = 1'b1; seq_is_status = st; seq_addr = a;
    @(negedge clk);
    seq_start = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic end_seq(input logic [2:0] bits);
    desel = 1'b1; desel_bits = bits;
    @(negedge clk);
    desel = 1'b0; desel_bits = 3'd0;
  endtask

  task automatic put_last(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b; desel = 1'b1; desel_bits = 3'd0;
    @(negedge clk);
    rx_valid = 1'b0; desel = 1'b0;
  endtask

  // expected array write from pl[0..n-1] starting at address a
  task automatic expect_arr(input logic [AW-1:0] a, input int n);
    exp_t e;
    e.is_sr = 1'b0; e.page = a[AW-1:4]; e.be = '0; e.data = '0;
    for (int i = 0; i < n; i++) begin
      int pos;
      pos = (a[3:0] + i) % 16;
      e.be[pos] = 1'b1;
      e.data[pos*8 +: 8] = pl[i];
    end
    q.push_back(e);
  endtask

  task automatic expect_sr(input logic [7:0] b);
    exp_t e;
    e = '0; e.is_sr = 1'b1; e.data[7:0] = b;
    q.push_back(e);
  endtask

  task automatic array_seq(input logic [AW-1:0] a, input int n);
    start_seq(1'b0, a);
    for (int i = 0; i < n; i++) put_byte(pl[i]);
  endtask

  task automatic settle();
    repeat (CYC + 4) @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R2", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && wel_clr == 0 && arr_we == 0 && sr_we == 0, "R1", "reset outputs",
        {busy, wel_clr, arr_we, sr_we}, 0);

    // R2/R3 single byte at 0x123
    pl[0] = 8'h5A;
    array_seq(10'h123, 1); expect_arr(10'h123, 1); end_seq(3'd0);
    chk(busy == 1'b1, "R2", "busy after commit", busy, 1);
    settle();

    // R4 wrap across 15 -> 0
    pl[0] = 8'h11; pl[1] = 8'h22; pl[2] = 8'h33;
    array_seq(10'h08E, 3); expect_arr(10'h08E, 3); end_seq(3'd0);
    settle();

    // R4 overwrite: 18 bytes from offset 0
    for (int i = 0; i < 18; i++) pl[i] = 8'(8'hC0 + i);
    array_seq(10'h3F0, 18); expect_arr(10'h3F0, 18); end_seq(3'd0);
    settle();

    // R5 partial byte at deselect
    pl[0] = 8'h01; pl[1] = 8'h02;
    array_seq(10'h200, 2); end_seq(3'd3);
    settle();
    chk(busy == 1'b0, "R5", "no cycle after partial byte", busy, 0);

    // R6 deselect with no data byte
    start_seq(1'b0, 10'h044); end_seq(3'd0);
    settle();
    chk(busy == 1'b0, "R6", "no cycle without data", busy, 0);

    // R7 status: one byte commits
    start_seq(1'b1, 10'h000); put_byte(8'h0C); expect_sr(8'h0C); end_seq(3'd0);
    settle();
    // R7 status: two bytes cancel
    start_seq(1'b1, 10'h000); put_byte(8'h04); put_byte(8'h08); end_seq(3'd0);
    settle();
    chk(busy == 1'b0, "R7", "two status bytes cancel", busy, 0);
    // R7 status: partial ninth bit cancels
    start_seq(1'b1, 10'h000); put_byte(8'h04); end_seq(3'd1);
    settle();
    chk(busy == 1'b0, "R7", "partial status byte cancels", busy, 0);

    // R9 last byte with deselect in one cycle
    pl[0] = 8'hAB; pl[1] = 8'hCD;
    start_seq(1'b0, 10'h155); put_byte(pl[0]); expect_arr(10'h155, 2); put_last(pl[1]);
    chk(busy == 1'b1, "R9", "commit with same-cycle byte", busy, 1);
    settle();
    // R9 single byte with deselect in one cycle
    pl[0] = 8'h9E;
    start_seq(1'b0, 10'h0F7); expect_arr(10'h0F7, 1); put_last(pl[0]);
    settle();

    // R8 activity during busy is ignored
    pl[0] = 8'hA0; pl[1] = 8'hA1;
    array_seq(10'h040, 2); expect_arr(10'h040, 2); end_seq(3'd0);
    start_seq(1'b0, 10'h040); put_byte(8'hEE); put_byte(8'hEE); put_byte(8'hEE); end_seq(3'd0);
    while (!wel_clr) @(negedge clk);
    start_seq(1'b0, 10'h050);   // sampled in the final busy cycle
    put_byte(8'h77); end_seq(3'd0);
    settle();
    chk(busy == 1'b0, "R8", "start in final cycle ignored", busy, 0);
    chk(q.size() == 0, "R8", "scoreboard drained", q.size(), 0);

    report();
  end
endmodule